// File: doc/BRIEF.md
# Mixed Latched/Live Status Word with Interrupt Mask

This block collects the status of a peripheral into a single 32-bit word. Some positions are event flags. A one-cycle pulse on the matching input sets the flag, and it stays set until software clears it. Other positions show condition levels such as buffer full or buffer empty directly, with no latching. All remaining positions always read as zero. Which positions hold which kind is chosen by two mask parameters. By default, bits 29, 21 and 11:0 are latched and bits 20:12 are live.

Software clears latched flags through a write-only clear port. When the clear strobe is high, every position written with 1 clears its latched flag. Positions written with 0 are unchanged. Writes to live or unused positions have no effect.

A separate mask register selects which status bits can raise the single interrupt line. The mask resets to zero, so the interrupt stays low until software enables at least one source.

Top module: `irq_status_word`

## Requirements
- R1: A latched position becomes 1 on the clock edge where its event input is high, and then holds its value while neither an event nor a clear reaches it.
- R2: With the clear strobe high, a 1 in a latched position of the clear data makes that status bit 0 at the next edge. A 0 in the clear data leaves the bit unchanged.
- R3: When an event and a clear reach the same latched position on the same edge, the bit ends up 1.
- R4: A live position equals its level input in the same cycle, with no storage, and is not affected by clears.
- R5: Clear writes to live or unused positions change nothing. Unused positions read 0 whatever the event and level inputs do. Event inputs at non-latched positions and level inputs at non-live positions are ignored.
- R6: With the mask strobe high, the mask register takes the mask data at the next edge and reads it back on the mask output. Otherwise it holds its value. Its reset value is all zeros.
- R7: The interrupt output is 1 exactly when some status bit and its mask bit are both 1.
- R8: While reset (active low) is asserted, all latched flags are 0 and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per position |
| lvl_i | input | 32 | Live condition levels, one per position |
| clr_we_i | input | 1 | Clear port write strobe |
| clr_data_i | input | 32 | Clear port data, 1 means clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_data_i | input | 32 | Mask write data |
| status_o | output | 32 | Status word |
| mask_o | output | 32 | Mask readback |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives an event and a clear into the same latched bit on the same edge. A design that gave the clear priority would lose that event.

It also sends an all-ones clear while live levels are high, and drives events and levels into unused positions. A design that latched live bits, or that did not tie unused bits to zero, would show stale or stray ones in the status word.

Finally, it toggles the mask around pending flags. An interrupt built from the unmasked status, or from a stale mask, would then go high or stay low in the wrong cycles.

// File: rtl/sts_pkg.sv
package sts_pkg;
   localparam int unsigned STS_W = 32;
   localparam logic [STS_W-1:0] DFLT_LATCH = 32'h2020_0FFF;
   localparam logic [STS_W-1:0] DFLT_LIVE  = 32'h001F_F000;

   typedef enum logic [1:0] {
      POS_UNUSED = 2'd0,
      POS_LIVE   = 2'd1,
      POS_LATCH  = 2'd2
   } pos_kind_e;

   function automatic pos_kind_e kind_of(input logic latch_b, input logic live_b);
      if (latch_b) return POS_LATCH;
      if (live_b)  return POS_LIVE;
      return POS_UNUSED;
   endfunction
endpackage

// File: rtl/sts_latch_bank.sv
module sts_latch_bank #(
   parameter int unsigned W = 32,
   parameter logic [W-1:0] SET_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   logic unused_inputs;
   assign unused_inputs = ^(set_i & ~SET_MASK) ^ ^(clr_i & ~SET_MASK);

   for (genvar i = 0; i < W; i++) begin : g_pos
      if (SET_MASK[i]) begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
         end

         p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
         p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> $stable(q_o[i]));
         p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
         p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && set_i[i]) |=> q_o[i]);
      end else begin : g_zero
         assign q_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/sts_mask_reg.sv
module sts_mask_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == $past(d_i)));
   p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/sts_irq_reduce.sv
module sts_irq_reduce #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] status_i,
   input  logic [W-1:0] enable_i,
   output logic         irq_o
);
   logic [W-1:0] hit;
   assign hit   = status_i & enable_i;
   assign irq_o = |hit;
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
   import sts_pkg::*;
#(
   parameter int unsigned W = STS_W,
   parameter logic [W-1:0] LATCH_MASK = DFLT_LATCH,
   parameter logic [W-1:0] LIVE_MASK  = DFLT_LIVE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_i,
   input  logic [W-1:0] lvl_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_data_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_data_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);
   localparam logic [W-1:0] USED_MASK = LATCH_MASK | LIVE_MASK;

   if (W < 1) begin : g_bad_width
      $error("status width must be at least one bit");
   end
   if ((LATCH_MASK & LIVE_MASK) != '0) begin : g_bad_overlap
      $error("a position cannot be both latched and live");
   end

   logic [W-1:0] clr_eff;
   logic [W-1:0] latched;
   logic [W-1:0] live;

   assign clr_eff = clr_we_i ? clr_data_i : '0;

   sts_latch_bank #(.W(W), .SET_MASK(LATCH_MASK)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_i),
      .clr_i (clr_eff),
      .q_o   (latched)
   );

   for (genvar i = 0; i < W; i++) begin : g_word
      localparam pos_kind_e KIND = kind_of(LATCH_MASK[i], LIVE_MASK[i]);
      if (KIND == POS_LIVE) begin : g_live
         assign live[i]     = lvl_i[i];
         assign status_o[i] = live[i];
      end else if (KIND == POS_LATCH) begin : g_lat
         assign live[i]     = 1'b0;
         assign status_o[i] = latched[i];
      end else begin : g_none
         assign live[i]     = 1'b0;
         assign status_o[i] = 1'b0;
      end
   end

   logic unused_inputs;
   assign unused_inputs = ^(lvl_i & ~LIVE_MASK) ^ ^live;

   sts_mask_reg #(.W(W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (mask_we_i),
      .d_i   (mask_data_i),
      .q_o   (mask_o)
   );

   sts_irq_reduce #(.W(W)) u_irq (
      .status_i (status_o),
      .enable_i (mask_o),
      .irq_o    (irq_o)
   );

   p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~USED_MASK) == '0);
   p_irq_masked_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o == '0) |-> !irq_o);
   p_irq_no_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == '0) |-> !irq_o);
   p_live_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(lvl_i) && clr_we_i) |=> ((status_o & LIVE_MASK) == ($past(status_o) & LIVE_MASK)));
endmodule

// File: tb/test_irq_status_word.sv
module test_irq_status_word;
   localparam logic [31:0] LAT  = 32'h2020_0FFF;
   localparam logic [31:0] LIV  = 32'h001F_F000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0, lvl = '0, clr_data = '0, mask_data = '0;
   logic        clr_we = 1'b0, mask_we = 1'b0;
   logic [31:0] status, mask;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] m_lat = '0, m_mask = '0;
   logic [31:0] exp_status;
   logic        exp_irq;
   bit          done = 0;

   always #5 clk = ~clk;

   irq_status_word i_irq_status_word (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .lvl_i(lvl),
      .clr_we_i(clr_we), .clr_data_i(clr_data),
      .mask_we_i(mask_we), .mask_data_i(mask_data),
      .status_o(status), .mask_o(mask), .irq_o(irq)
   );

   // behavioural reference
   always @(posedge clk) begin
      if (!rst_n) begin
         m_lat  <= '0;
         m_mask <= '0;
      end else begin
         m_lat  <= ((m_lat & ~(clr_we ? clr_data : 32'h0)) | evt) & LAT;
         if (mask_we) m_mask <= mask_data;
      end
   end

   always_comb begin
      exp_status = m_lat | (lvl & LIV);
      exp_irq    = |(exp_status & m_mask);
   end

   task automatic chk32(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk32(status, exp_status, "R1 R2 R3 R4 R5 status");
         chk32(mask, m_mask, "R6 mask");
         chk32({31'h0, irq}, {31'h0, exp_irq}, "R7 irq");
      end
   end

   task automatic drive(input logic [31:0] e, input logic [31:0] l,
                        input logic cw, input logic [31:0] cd,
                        input logic mw, input logic [31:0] md);
      @(posedge clk); #1;
      evt = e; lvl = l; clr_we = cw; clr_data = cd; mask_we = mw; mask_data = md;
   endtask

   initial begin
      #200_000ns;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk32(status, 32'h0, "R8 reset status");
      chk32(mask, 32'h0, "R8 reset mask");
      drive('0, '0, 0, '0, 0, '0);
      rst_n = 1'b1;
      // R1 set and hold
      drive(32'h2000_0001, '0, 0, '0, 0, '0);
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk); chk32(status, 32'h2000_0001, "R1 latched hold");
      // R7 no interrupt while mask zero
      chk32({31'h0, irq}, 32'h0, "R7 masked off");
      drive('0, '0, 0, '0, 1, 32'h0000_0001);
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk); chk32({31'h0, irq}, 32'h1, "R7 enabled source");
      chk32(mask, 32'h1, "R6 readback");
      // R2 clear with zeros elsewhere
      drive('0, '0, 1, 32'h0000_0001, 0, '0);
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk); chk32(status, 32'h2000_0000, "R2 w1c");
      chk32({31'h0, irq}, 32'h0, "R7 cleared source");
      // R3 set wins
      drive(32'h0020_0000, '0, 1, 32'h0020_0000, 0, '0);
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk); chk32(status & 32'h0020_0000, 32'h0020_0000, "R3 set wins");
      // R4 live follows same cycle
      drive('0, 32'h0000_5000, 0, '0, 0, '0);
      @(negedge clk); chk32(status & LIV, 32'h0000_5000, "R4 live follow");
      // R5 clear all with live high, strays on unused positions
      drive(32'hDFDF_F000, 32'hFFFF_FFFF, 1, 32'hFFFF_FFFF, 0, '0);
      drive('0, 32'hFFFF_FFFF, 0, '0, 0, '0);
      @(negedge clk); chk32(status, LIV, "R5 only live remain");
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk); chk32(status, 32'h0, "R4 live drop");
      // pseudo-random traffic checked cycle by cycle
      for (int k = 0; k < 400; k++) begin
         drive($urandom & $urandom & $urandom, $urandom,
               ($urandom % 4) == 0, $urandom,
               ($urandom % 8) == 0, $urandom);
      end
      drive('0, '0, 0, '0, 0, '0);
      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule